// File: doc/BRIEF.md
# Quad Decrementing Timer

The block holds a set of independent down-counters (four by default) behind a small word-addressed register bus. Software arms a channel by writing its control word and then a start value. From then on the channel counts down at the system clock divided by 1, 16 or 256. When a channel reaches zero it raises its bit in a shared raw interrupt register. What happens at the next tick depends on the mode. A one-shot channel parks at zero. A periodic channel restarts from its reload value. A free-running channel wraps to the all-ones value of its active width.

Each channel keeps a reload value next to its live count. A write to the start register replaces the live count at once and also sets the reload value. A write to the reload register changes only what a periodic channel restarts from at its next wrap. A channel can count over the full word or over its low half only. The shared interrupt section has a mask register, a raw status register, a masked view of the raw status, a write-one-to-clear port and a single interrupt output. Reads are combinational on the word index.

Top module: `qtimer_unit`

## Requirements
- R1: After reset every channel's count, control word and reload value read 0, the raw status and the mask read 0, and `irq` is low.
- R2: Register map, by byte offset. Shared registers: 0x00 mask, 0x04 raw status, 0x08 masked status, 0x0C clear. Channel n sits at 0x10+0x10*n, with +0x0 start, +0x4 count, +0x8 control and +0xC reload. A write to start is visible at the count register with no tick lost or added. It also sets the reload value, which both +0x0 and +0xC read back.
- R3: Control bits: 7 enable, 6 periodic, 3:2 prescale, 1 full width, 0 one-shot. With enable set, the count drops by one every D clocks after the start write, where D is 1 for code 00, 16 for code 01 and 256 for codes 10 and 11. After k clocks the count reads start − floor(k/D).
- R4: With enable clear the count holds its value.
- R5: The tick that takes a count from 1 to 0 sets raw status bit n for channel n.
- R6: With bit 0 set, a channel that has reached zero stays at zero and raises no further interrupt until its start register is written.
- R7: With bit 0 clear and bit 6 set, the tick after zero loads the reload value, masked to the active width.
- R8: With bits 0 and 6 clear, the tick after zero loads the all-ones value of the active width.
- R9: A write to the reload register leaves the live count unchanged.
- R10: With bit 1 clear, only the low half of the count (16 bits by default) counts. The count reads zero-extended and wraps to the all-ones value of the low half.
- R11: The mask register reads back what was written. Masked status reads raw AND mask. `irq` is high exactly when masked status is non-zero.
- R12: Writing 1 to a bit of the clear register clears that raw bit. A zero-crossing in the same cycle wins, so the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_word | input | 6 | Word index (byte offset divided by four) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| irq | output | 1 | OR of masked interrupt status |

## Verification
A corrupt prescaler phase shows up as a count that is off by one tick at a D-aligned sample point, within one prescale period of the start write. A wrong reload or wrap path shows at the count register one tick after zero, and a lost or spurious zero-crossing shows in raw status during that same tick. The bench samples the count exactly at D−1, D, 2D and the zero and wrap points for every channel and every prescale code, so a single-cycle slip is caught.

// File: rtl/qtimer_pkg.sv
// Package: shared field positions, register selectors and prescale decode
// for the quad decrementing timer. Assumes 32-bit data words.
package qtimer_pkg;
    localparam int CTL_EN    = 7;
    localparam int CTL_PER   = 6;
    localparam int CTL_PS_HI = 3;
    localparam int CTL_PS_LO = 2;
    localparam int CTL_WIDE  = 1;
    localparam int CTL_ONE   = 0;
    localparam int CTL_W     = 8;
    localparam int PS_W      = 8;

    // Register selector inside one 16-byte group
    localparam logic [1:0] SEL_START  = 2'd0;
    localparam logic [1:0] SEL_COUNT  = 2'd1;
    localparam logic [1:0] SEL_CTL    = 2'd2;
    localparam logic [1:0] SEL_RELOAD = 2'd3;

    // Selector inside the shared group
    localparam logic [1:0] SEL_MASK = 2'd0;
    localparam logic [1:0] SEL_RAW  = 2'd1;
    localparam logic [1:0] SEL_MIS  = 2'd2;
    localparam logic [1:0] SEL_CLR  = 2'd3;

    // Terminal prescale count for a control code (divide = limit + 1)
    function automatic logic [PS_W-1:0] ps_limit(input logic [1:0] code);
        case (code)
            2'b00:   return 8'd0;
            2'b01:   return 8'd15;
            default: return 8'd255;
        endcase
    endfunction
endpackage

// File: rtl/qtimer_prescale.sv
// Module: per-channel prescaler. Emits a one-cycle tick every (limit+1)
// clocks while run is high. Restart or stop zeroes the phase, so the
// first tick after a restart lands limit+1 clocks later.
module qtimer_prescale #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] limit,
    output logic            tick
);
    logic [PS_W-1:0] phase;

    assign tick = run && !restart && (phase >= limit);

    // Advance the phase counter, wrapping at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n)                  phase <= '0;
        else if (restart || !run)    phase <= '0;
        else if (phase >= limit)     phase <= '0;
        else                         phase <= phase + 1'b1;
    end
endmodule

// File: rtl/qtimer_channel.sv
// Module: one decrementing channel with live count, reload value and
// control word. Assumes CNT_W is even; narrow mode uses the low half.
// hit is combinational and marks the tick that takes the count to zero.
module qtimer_channel
    import qtimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_we,
    input  logic             reload_we,
    input  logic             ctl_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl_q,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             hit
);
    localparam int NARROW_W = CNT_W / 2;

    logic [CTL_W-1:0] ctl;
    logic [CNT_W-1:0] cur, rel, nxt, wmask, cur_m;
    logic             tick;

    assign wmask = ctl[CTL_WIDE] ? {CNT_W{1'b1}}
                                 : {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    assign cur_m    = cur & wmask;
    assign count_q  = cur_m;
    assign reload_q = rel;
    assign ctl_q    = ctl;

    qtimer_prescale #(.PS_W(PS_W)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl[CTL_EN]),
        .restart (start_we),
        .limit   (ps_limit(ctl[CTL_PS_HI:CTL_PS_LO])),
        .tick    (tick)
    );

    // Next-count selection: start write, decrement, or zero handling
    always_comb begin
        nxt = cur;
        hit = 1'b0;
        if (start_we) begin
            nxt = wdata;
        end else if (tick) begin
            if (cur_m == '0) begin
                if (ctl[CTL_ONE])      nxt = '0;
                else if (ctl[CTL_PER]) nxt = rel & wmask;
                else                   nxt = wmask;
            end else begin
                nxt = (cur_m - 1'b1) & wmask;
                hit = (cur_m == {{(CNT_W-1){1'b0}}, 1'b1});
            end
        end
    end

    // Live count register
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= '0;
        else        cur <= nxt;
    end

    // Reload value: set by start and reload writes
    always_ff @(posedge clk) begin
        if (!rst_n)                   rel <= '0;
        else if (start_we || reload_we) rel <= wdata;
    end

    // Control word
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl <= '0;
        else if (ctl_we) ctl <= wdata[CTL_W-1:0];
    end
endmodule

// File: rtl/qtimer_irq.sv
// Module: shared interrupt section. Raw bits are set by channel hits and
// cleared by write-one; a hit in the same cycle wins over the clear.
module qtimer_irq #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] raw_q,
    output logic              irq
);
    logic [NUM_CH-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;
    assign irq      = |(raw_q & mask_q);

    // Raw status: clear-by-write, set-by-hit with priority to set
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_bits) | hit;
    end

    // Interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wbits;
    end
endmodule

// File: rtl/qtimer_unit.sv
// Module: top of the quad decrementing timer. Decodes a word index into
// the shared group (index 0..3) and one 4-word group per channel, and
// drives read data combinationally. Assumes NUM_CH <= 15.
module qtimer_unit
    import qtimer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_wr,
    input  logic [5:0]       bus_word,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    logic [3:0] grp;
    logic [1:0] sel;
    logic       wr;

    logic [NUM_CH-1:0][CNT_W-1:0] ch_count, ch_reload;
    logic [NUM_CH-1:0][CTL_W-1:0] ch_ctl;
    logic [NUM_CH-1:0]            start_we, reload_we, ctl_we, hit;
    logic [NUM_CH-1:0]            ch_en, ch_one;
    logic [NUM_CH-1:0]            mask_q, raw_q;
    logic                         mask_we, clr_we;

    assign grp     = bus_word[5:2];
    assign sel     = bus_word[1:0];
    assign wr      = bus_en && bus_wr;
    assign mask_we = wr && (grp == 4'd0) && (sel == SEL_MASK);
    assign clr_we  = wr && (grp == 4'd0) && (sel == SEL_CLR);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit_grp;
        assign hit_grp      = wr && (grp == 4'(i + 1));
        assign start_we[i]  = hit_grp && (sel == SEL_START);
        assign reload_we[i] = hit_grp && (sel == SEL_RELOAD);
        assign ctl_we[i]    = hit_grp && (sel == SEL_CTL);
        assign ch_en[i]     = ch_ctl[i][CTL_EN];
        assign ch_one[i]    = ch_ctl[i][CTL_ONE];

        qtimer_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_we  (start_we[i]),
            .reload_we (reload_we[i]),
            .ctl_we    (ctl_we[i]),
            .wdata     (bus_wdata),
            .ctl_q     (ch_ctl[i]),
            .count_q   (ch_count[i]),
            .reload_q  (ch_reload[i]),
            .hit       (hit[i])
        );
    end

    qtimer_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .mask_we (mask_we),
        .clr_we  (clr_we),
        .wbits   (bus_wdata[NUM_CH-1:0]),
        .mask_q  (mask_q),
        .raw_q   (raw_q),
        .irq     (irq)
    );

    // Read multiplexer over shared and per-channel registers
    always_comb begin
        bus_rdata = '0;
        if (grp == 4'd0) begin
            case (sel)
                SEL_MASK: bus_rdata = {{(CNT_W-NUM_CH){1'b0}}, mask_q};
                SEL_RAW:  bus_rdata = {{(CNT_W-NUM_CH){1'b0}}, raw_q};
                SEL_MIS:  bus_rdata = {{(CNT_W-NUM_CH){1'b0}}, raw_q & mask_q};
                default:  bus_rdata = '0;
            endcase
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (grp == 4'(i + 1)) begin
                case (sel)
                    SEL_COUNT: bus_rdata = ch_count[i];
                    SEL_CTL:   bus_rdata = {{(CNT_W-CTL_W){1'b0}}, ch_ctl[i]};
                    default:   bus_rdata = ch_reload[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/qtimer_checker.sv
// Module: assertion checker for qtimer_unit, attached by bind. Relates
// channel counts, control bits, hits and raw status across cycles.
module qtimer_checker #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_count,
    input logic [NUM_CH-1:0]            ch_en,
    input logic [NUM_CH-1:0]            ch_one,
    input logic [NUM_CH-1:0]            start_we,
    input logic [NUM_CH-1:0]            ctl_we,
    input logic [NUM_CH-1:0]            hit,
    input logic [NUM_CH-1:0]            raw_q,
    input logic                         clr_we,
    input logic [NUM_CH-1:0]            wbits
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[i] && ch_count[i] != '0 && !start_we[i] && !ctl_we[i])
            |=> (ch_count[i] == $past(ch_count[i]) || ch_count[i] == $past(ch_count[i]) - 1'b1)); // R3
        AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[i] && !start_we[i] && !ctl_we[i]) |=> $stable(ch_count[i])); // R4
        AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[i] && ch_one[i] && ch_count[i] == '0 && !start_we[i] && !ctl_we[i])
            |=> (ch_count[i] == '0)); // R6
        AST_HIT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> raw_q[i]); // R5
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && wbits[i] && !hit[i]) |=> !raw_q[i]); // R12
    end
endmodule

bind qtimer_unit qtimer_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_count (ch_count),
    .ch_en    (ch_en),
    .ch_one   (ch_one),
    .start_we (start_we),
    .ctl_we   (ctl_we),
    .hit      (hit),
    .raw_q    (raw_q),
    .clr_we   (clr_we),
    .wbits    (bus_wdata[NUM_CH-1:0])
);

// File: tb/sim_qtimer_unit.sv
`timescale 1ns/1ps
// Bench: sweeps every channel over every prescale code, then mode,
// width, reload and interrupt cases, with expected values computed here.
module sim_qtimer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;

    localparam logic [7:0] O_MASK = 8'h00, O_RAW = 8'h04, O_MIS = 8'h08, O_CLR = 8'h0C;

    always #2 clk = ~clk;

    qtimer_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] cb(input int ch);
        return 8'(8'h10 + 8'h10 * ch);
    endfunction

    // Write one word; called just after a falling edge, returns on the next
    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_word = off[7:2]; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    // Combinational read, consumes no clock
    task automatic rd(input logic [7:0] off, output logic [31:0] d);
        bus_word = off[7:2];
        #0.1;
        d = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rdchk(input string req, input logic [7:0] off, input logic [31:0] exp);
        logic [31:0] d;
        rd(off, d);
        chk(req, d, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int c = 0; c < 4; c++) begin
            rdchk("R1 count", cb(c) + 8'h4, 32'h0);
            rdchk("R1 ctl", cb(c) + 8'h8, 32'h0);
            rdchk("R1 reload", cb(c) + 8'hC, 32'h0);
        end
        rdchk("R1 raw", O_RAW, 32'h0);
        rdchk("R1 mask", O_MASK, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2/R3/R5/R8: sweep channels and prescale codes, free-running wide
        for (int c = 0; c < 4; c++) begin
            for (int code = 0; code < 4; code++) begin
                int dv, el;
                int ks[5];
                dv = (code == 0) ? 1 : (code == 1) ? 16 : 256;
                wr(cb(c) + 8'h8, 32'h0);
                wr(O_CLR, 32'hF);
                wr(cb(c) + 8'h8, 32'h82 | (code << 2));
                wr(cb(c), 32'd3);
                rdchk("R2 start visible", cb(c) + 8'h4, 32'd3);
                rdchk("R2 reload from start", cb(c), 32'd3);
                rdchk("R2 reload offset", cb(c) + 8'hC, 32'd3);
                ks[0] = dv - 1; ks[1] = dv; ks[2] = 2 * dv; ks[3] = 3 * dv; ks[4] = 4 * dv;
                el = 0;
                for (int j = 0; j < 5; j++) begin
                    wait_cyc(ks[j] - el);
                    el = ks[j];
                    if (ks[j] < 3 * dv)       e = 32'(3 - ks[j] / dv);
                    else if (ks[j] == 3 * dv) e = 32'h0;
                    else                      e = 32'hFFFF_FFFF;
                    rd(cb(c) + 8'h4, d);
                    chk(j == 4 ? "R8 wrap" : "R3 prescaled count", d, e);
                    if (j == 3) rdchk("R5 raw bit", O_RAW, 32'(1 << c));
                end
                wr(cb(c) + 8'h8, 32'h0);
                rd(cb(c) + 8'h4, d);
                wait_cyc(5);
                rdchk("R4 hold after disable", cb(c) + 8'h4, d);
            end
        end

        // R4: disabled channel ignores time
        wr(cb(0) + 8'h8, 32'h02);
        wr(cb(0), 32'd9);
        wait_cyc(20);
        rdchk("R4 disabled hold", cb(0) + 8'h4, 32'd9);

        // R6: one-shot parks at zero
        wr(cb(1) + 8'h8, 32'h0);
        wr(O_CLR, 32'hF);
        wr(cb(1) + 8'h8, 32'h83);
        wr(cb(1), 32'd3);
        wait_cyc(3);
        rdchk("R6 reaches zero", cb(1) + 8'h4, 32'h0);
        rdchk("R5 one-shot raw", O_RAW, 32'h2);
        wr(O_CLR, 32'h2);
        wait_cyc(10);
        rdchk("R6 stays zero", cb(1) + 8'h4, 32'h0);
        rdchk("R6 no new irq", O_RAW, 32'h0);

        // R12: clear in the same cycle as a zero-crossing loses
        wr(cb(1), 32'd3);
        wait_cyc(2);
        wr(O_CLR, 32'h2);
        rdchk("R12 set wins", O_RAW, 32'h2);
        rdchk("R12 count zero", cb(1) + 8'h4, 32'h0);
        wr(O_CLR, 32'h2);
        rdchk("R12 clear", O_RAW, 32'h0);

        // R7/R9: periodic with reload written after start
        wr(cb(2) + 8'h8, 32'hC2);
        wr(cb(2), 32'd2);
        wr(cb(2) + 8'hC, 32'd7);
        rdchk("R9 count untouched", cb(2) + 8'h4, 32'd1);
        rdchk("R9 reload readback", cb(2), 32'd7);
        wait_cyc(1);
        rdchk("R7 zero", cb(2) + 8'h4, 32'h0);
        wait_cyc(1);
        rdchk("R7 reload", cb(2) + 8'h4, 32'd7);
        wait_cyc(1);
        rdchk("R7 after reload", cb(2) + 8'h4, 32'd6);
        wait_cyc(7);
        rdchk("R7 second reload", cb(2) + 8'h4, 32'd7);

        // R10: narrow counting
        wr(cb(3) + 8'h8, 32'h80);
        wr(cb(3), 32'h1234_0002);
        rdchk("R10 zero-extended", cb(3) + 8'h4, 32'h2);
        wait_cyc(2);
        rdchk("R10 zero", cb(3) + 8'h4, 32'h0);
        wait_cyc(1);
        rdchk("R10 narrow wrap", cb(3) + 8'h4, 32'h0000_FFFF);
        wait_cyc(1);
        rdchk("R10 narrow step", cb(3) + 8'h4, 32'h0000_FFFE);

        // R11: mask, masked status and irq pin
        wr(cb(2) + 8'h8, 32'h0);
        wr(cb(3) + 8'h8, 32'h0);
        wr(cb(0) + 8'h8, 32'h83);
        wr(cb(1) + 8'h8, 32'h83);
        wr(O_CLR, 32'hF);
        wr(cb(0), 32'd1);
        wr(cb(1), 32'd1);
        wait_cyc(2);
        rdchk("R11 raw pair", O_RAW, 32'h3);
        wr(O_MASK, 32'h1);
        rdchk("R11 mask readback", O_MASK, 32'h1);
        rdchk("R11 masked status", O_MIS, 32'h1);
        chk("R11 irq high", {31'b0, irq}, 32'h1);
        wr(O_MASK, 32'h4);
        rdchk("R11 masked none", O_MIS, 32'h0);
        chk("R11 irq low", {31'b0, irq}, 32'h0);
        wr(O_MASK, 32'h2);
        chk("R11 irq other bit", {31'b0, irq}, 32'h1);
        wr(O_CLR, 32'h2);
        rdchk("R12 partial clear", O_RAW, 32'h1);
        chk("R11 irq after clear", {31'b0, irq}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule